// File: doc/BRIEF.md
# Windowed Independent Watchdog with Key-Protected Configuration

This block is a watchdog timer that runs from its own slow clock, independent of the bus clock. A 12-bit down-counter is decremented once per divided slow-clock tick. If software fails to refresh it in time, the counter reaches zero and the block raises a sticky reset request. Software controls the watchdog by writing magic key values to a key register. One key starts the watchdog, one refreshes the counter and one unlocks the three configuration registers. The configuration registers hold the clock divider, the reload value and the window limit.

Configuration writes are made in the bus domain and then transferred into the slow domain with toggle handshakes. Each of the three registers has a busy bit in the status register, which stays set until its transfer has been acknowledged. A refresh that arrives while the counter is still above the window limit counts as a fault and triggers the reset at once. A write to the window register always reloads the counter. A debug-halt input freezes the counter. A strap input can start the watchdog at reset without any software action.

Top module: `iwd_top`

## Requirements
- R1: Once running, the counter decrements by one on every divided slow-clock tick. After it is loaded with value L at divisor D, the reset request asserts about L*D slow cycles later, plus a fixed synchronizer latency of a few slow cycles.
- R2: Writing 0xAAAA to the key register (address 0) while running, and with the counter at or below the window limit, loads the counter from the reload register.
- R3: Writing 0x5555 to the key register unlocks the protected registers. Writing any other key value locks them again. A write to the divider (address 1), the reload (address 2) or the window (address 3) while locked leaves that register unchanged.
- R4: Key 0xCCCC starts the watchdog, and no later key write can stop it. Before the watchdog starts, refresh and window reloads are ignored and the counter stays at 0xFFF.
- R5: When the hw_enable strap is high during slow reset, the watchdog runs from 0xFFF with no software start. With the reset divider of 4, the reset request follows after about 0xFFF*4 slow cycles.
- R6: While running, a write to the window register reloads the counter from the reload register. This happens even when the value written is 0xFFF.
- R7: The status register (address 4) has bit 0 for the divider, bit 1 for reload and bit 2 for window. A bit sets on an accepted write and clears once the slow domain has taken the value. A write to a register whose busy bit is set is ignored.
- R8: While dbg_halt is high, the counter holds and no reset request is raised. Counting resumes after dbg_halt is released.
- R9: A divider code c from 0 to 5 divides the slow clock by 4<<c. Codes 6 and 7 both divide by 256.
- R10: A refresh arriving while the counter is above the window limit asserts the reset request within a few slow cycles. The window limit resets to 0xFFF, which disables this check.
- R11: Once asserted, the reset request stays high until slow_rst.
- R12: After reset, reads return divider 0, reload 0xFFF, window 0xFFF, status 0 and key 0, and the reset request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | Independent slow counting clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| hw_enable | input | 1 | Strap: run from reset without a software start |
| dbg_halt | input | 1 | Freezes the counter while high |
| bus_wr | input | 1 | Write strobe for one bus cycle |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| wdg_reset_req | output | 1 | Sticky reset request, slow domain |

## Verification
The assertions rely on a few input conditions. The two clocks must be free-running. A bus write lasts exactly one clk cycle. hw_enable is static while slow_rst is low. The stimulus meets these conditions by driving every bus write as a single-cycle strobe on the falling clock edge and by changing hw_enable only inside a reset. It also lets the start key settle across the domain crossing before the first refresh, so that a refresh never races the start. The timing checks use bounds that cover the synchronizer latency. Outside those bounds the expected times are exact products of the reload value and the divisor.

// File: rtl/iwd_pkg.sv
package iwd_pkg;

    localparam int KEY_W      = 16;
    localparam int CNT_W      = 12;
    localparam int DIV_CODE_W = 3;
    localparam int PRE_W      = 8;   // log2 of the largest divisor
    localparam int MIN_SHIFT  = 2;   // smallest divisor is 4
    localparam int N_CFG      = 3;
    localparam int ADDR_W     = 3;

    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

    typedef enum logic [ADDR_W-1:0] {
        SEL_KEY    = 3'd0,
        SEL_DIV    = 3'd1,
        SEL_RELOAD = 3'd2,
        SEL_WINDOW = 3'd3,
        SEL_STATUS = 3'd4
    } reg_sel_e;

    // index of each configuration field in busy / toggle vectors
    localparam int IDX_DIV    = 0;
    localparam int IDX_RELOAD = 1;
    localparam int IDX_WINDOW = 2;

    typedef struct packed {
        logic [DIV_CODE_W-1:0] div_code;
        logic [CNT_W-1:0]      reload;
        logic [CNT_W-1:0]      window;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{div_code: '0, reload: '1, window: '1};

    // terminal value of the prescaler for a divider code
    function automatic logic [PRE_W-1:0] div_limit(input logic [DIV_CODE_W-1:0] code);
        int unsigned sh;
        sh = int'(code) + MIN_SHIFT;
        if (sh > PRE_W) sh = PRE_W;
        return PRE_W'((32'd1 << sh) - 32'd1);
    endfunction

endpackage

// File: rtl/iwd_sync.sv
module iwd_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/iwd_bus_regs.sv
module iwd_bus_regs
    import iwd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CFG-1:0]  ack_tgl_sync,
    output cfg_t              shadow,
    output logic [N_CFG-1:0]  cfg_tgl,
    output logic              refresh_tgl,
    output logic              start_lvl
);
    reg_sel_e         sel;
    logic [KEY_W-1:0] key;
    logic             key_wr;
    logic             unlock_q;
    logic [N_CFG-1:0] busy_q;
    logic [N_CFG-1:0] ack_seen_q;
    logic [N_CFG-1:0] ack_edge;
    logic [N_CFG-1:0] accept;
    cfg_t             shadow_q;
    logic [N_CFG-1:0] tgl_q;
    logic             refresh_q;
    logic             start_q;

    assign sel      = reg_sel_e'(bus_addr);
    assign key      = bus_wdata[KEY_W-1:0];
    assign key_wr   = bus_wr && (sel == SEL_KEY);
    assign ack_edge = ack_tgl_sync ^ ack_seen_q;

    for (genvar i = 0; i < N_CFG; i++) begin : g_accept
        assign accept[i] = bus_wr && unlock_q && !busy_q[i]
                           && (bus_addr == ADDR_W'(int'(SEL_DIV) + i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q   <= 1'b0;
            busy_q     <= '0;
            ack_seen_q <= '0;
            shadow_q   <= CFG_RESET;
            tgl_q      <= '0;
            refresh_q  <= 1'b0;
            start_q    <= 1'b0;
        end else begin
            ack_seen_q <= ack_tgl_sync;
            if (key_wr) begin
                unlock_q <= (key == KEY_UNLOCK);
                if (key == KEY_REFRESH) refresh_q <= ~refresh_q;
                if (key == KEY_START)   start_q   <= 1'b1;
            end
            if (accept[IDX_DIV])    shadow_q.div_code <= bus_wdata[DIV_CODE_W-1:0];
            if (accept[IDX_RELOAD]) shadow_q.reload   <= bus_wdata[CNT_W-1:0];
            if (accept[IDX_WINDOW]) shadow_q.window   <= bus_wdata[CNT_W-1:0];
            for (int i = 0; i < N_CFG; i++) begin
                if (accept[i]) begin
                    busy_q[i] <= 1'b1;
                    tgl_q[i]  <= ~tgl_q[i];
                end else if (ack_edge[i]) begin
                    busy_q[i] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DIV:    bus_rdata = DATA_W'(shadow_q.div_code);
            SEL_RELOAD: bus_rdata = DATA_W'(shadow_q.reload);
            SEL_WINDOW: bus_rdata = DATA_W'(shadow_q.window);
            SEL_STATUS: bus_rdata = DATA_W'(busy_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign shadow      = shadow_q;
    assign cfg_tgl     = tgl_q;
    assign refresh_tgl = refresh_q;
    assign start_lvl   = start_q;

    assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !unlock_q && sel == SEL_RELOAD) |=> $stable(shadow_q.reload));

    assert_busy_blocks_write_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && busy_q[IDX_DIV] && sel == SEL_DIV) |=> $stable(shadow_q.div_code));

    assert_busy_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && unlock_q && !busy_q[IDX_WINDOW] && sel == SEL_WINDOW) |=> busy_q[IDX_WINDOW]);

    assert_start_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        start_q |=> start_q);
endmodule

// File: rtl/iwd_slow_core.sv
module iwd_slow_core
    import iwd_pkg::*;
(
    input  logic             slow_clk,
    input  logic             slow_rst,
    input  logic             hw_enable,
    input  logic             halt_sync,
    input  logic             start_sync,
    input  logic             refresh_sync,
    input  logic [N_CFG-1:0] cfg_sync,
    input  cfg_t             shadow,
    output logic [N_CFG-1:0] ack_tgl,
    output logic             reset_req
);
    logic [CNT_W-1:0] count_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_lim;
    cfg_t             live_q;
    logic             running_q;
    logic             req_q;
    logic             refresh_prev_q;
    logic [N_CFG-1:0] cfg_prev_q;
    logic             refresh_evt;
    logic [N_CFG-1:0] cfg_evt;
    logic             early;
    logic             load_evt;
    logic             advance;
    logic             tick;

    assign refresh_evt = refresh_sync ^ refresh_prev_q;
    assign cfg_evt     = cfg_sync ^ cfg_prev_q;
    assign early       = running_q && refresh_evt && (count_q > live_q.window);
    assign load_evt    = running_q && ((refresh_evt && !early) || cfg_evt[IDX_WINDOW]);
    assign advance     = running_q && !halt_sync && !req_q;
    assign pre_lim     = div_limit(live_q.div_code);
    assign tick        = (pre_q >= pre_lim);

    always_ff @(posedge slow_clk) begin
        if (slow_rst) begin
            count_q        <= '1;
            pre_q          <= '0;
            live_q         <= CFG_RESET;
            running_q      <= hw_enable;
            req_q          <= 1'b0;
            refresh_prev_q <= 1'b0;
            cfg_prev_q     <= '0;
        end else begin
            refresh_prev_q <= refresh_sync;
            cfg_prev_q     <= cfg_sync;
            if (start_sync) running_q <= 1'b1;
            if (cfg_evt[IDX_DIV])    live_q.div_code <= shadow.div_code;
            if (cfg_evt[IDX_RELOAD]) live_q.reload   <= shadow.reload;
            if (cfg_evt[IDX_WINDOW]) live_q.window   <= shadow.window;
            if (early || (running_q && count_q == '0)) req_q <= 1'b1;
            if (load_evt) begin
                count_q <= live_q.reload;
                pre_q   <= '0;
            end else if (advance) begin
                if (tick) begin
                    pre_q <= '0;
                    if (count_q != '0) count_q <= count_q - CNT_W'(1);
                end else begin
                    pre_q <= pre_q + PRE_W'(1);
                end
            end
        end
    end

    assign ack_tgl   = cfg_prev_q;
    assign reset_req = req_q;

    assert_req_sticky_R11: assert property (@(posedge slow_clk) disable iff (slow_rst)
        req_q |=> req_q);

    assert_running_sticky_R4: assert property (@(posedge slow_clk) disable iff (slow_rst)
        running_q |=> running_q);

    assert_freeze_R8: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (halt_sync && !load_evt) |=> $stable(count_q));

    assert_count_step_R1: assert property (@(posedge slow_clk) disable iff (slow_rst)
        !load_evt |=> (count_q == $past(count_q) || count_q == $past(count_q) - CNT_W'(1)));

    assert_early_refresh_R10: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (refresh_evt && running_q && count_q > live_q.window) |=> req_q);

    assert_stopped_holds_R4: assert property (@(posedge slow_clk) disable iff (slow_rst)
        !running_q |=> $stable(count_q));
endmodule

// File: rtl/iwd_top.sv
module iwd_top
    import iwd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_clk,
    input  logic              slow_rst,
    input  logic              hw_enable,
    input  logic              dbg_halt,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdg_reset_req
);
    localparam int FWD_W = N_CFG + 3;

    cfg_t             shadow;
    logic [N_CFG-1:0] cfg_tgl;
    logic             refresh_tgl;
    logic             start_lvl;
    logic [N_CFG-1:0] ack_tgl;
    logic [N_CFG-1:0] ack_tgl_sync;
    logic [FWD_W-1:0] fwd_sync;

    iwd_bus_regs #(.DATA_W(DATA_W)) regs_i (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ack_tgl_sync (ack_tgl_sync),
        .shadow       (shadow),
        .cfg_tgl      (cfg_tgl),
        .refresh_tgl  (refresh_tgl),
        .start_lvl    (start_lvl)
    );

    iwd_sync #(.W(FWD_W)) to_slow_i (
        .clk (slow_clk),
        .rst (slow_rst),
        .d   ({dbg_halt, start_lvl, refresh_tgl, cfg_tgl}),
        .q   (fwd_sync)
    );

    iwd_sync #(.W(N_CFG)) to_bus_i (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl),
        .q   (ack_tgl_sync)
    );

    iwd_slow_core core_i (
        .slow_clk     (slow_clk),
        .slow_rst     (slow_rst),
        .hw_enable    (hw_enable),
        .halt_sync    (fwd_sync[N_CFG+2]),
        .start_sync   (fwd_sync[N_CFG+1]),
        .refresh_sync (fwd_sync[N_CFG]),
        .cfg_sync     (fwd_sync[N_CFG-1:0]),
        .shadow       (shadow),
        .ack_tgl      (ack_tgl),
        .reset_req    (wdg_reset_req)
    );
endmodule

// File: tb/iwd_top_tb_top.sv
module iwd_top_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int SLOW_PERIOD = 34;

    logic clk = 1'b0, slow_clk = 1'b0;
    logic rst = 1'b1, slow_rst = 1'b1;
    logic hw_enable = 1'b0, dbg_halt = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdg_reset_req;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

    iwd_top dut_i (
        .clk(clk), .rst(rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
        .hw_enable(hw_enable), .dbg_halt(dbg_halt), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdg_reset_req(wdg_reset_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit hw);
        hw_enable = hw;
        dbg_halt  = 1'b0;
        rst = 1'b1; slow_rst = 1'b1;
        repeat (4) @(posedge slow_clk);
        @(negedge clk) rst = 1'b0;
        @(negedge slow_clk) slow_rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [15:0] s;
        int n;
        n = 0;
        rd(3'd4, s);
        while (s != 0 && n < 500) begin
            rd(3'd4, s);
            n++;
        end
        check(s == 0, req, int'(s), 0);
    endtask

    // counts slow cycles until the reset request is seen, up to limit
    task automatic slow_until_req(input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(negedge slow_clk);
            n++;
            if (wdg_reset_req) break;
        end
    endtask

    task automatic arm(input int code, input int rel);
        do_reset(1'b0);
        wr(3'd0, 16'h5555);
        wr(3'd1, 16'(code));
        wr(3'd2, 16'(rel));
        wait_idle("R7");
        wr(3'd0, 16'hCCCC);
        repeat (5) @(negedge slow_clk);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n, d, lo, hi;

        // R12 reset state
        do_reset(1'b0);
        rd(3'd1, v); check(v == 16'd0,     "R12 div reset", int'(v), 0);
        rd(3'd2, v); check(v == 16'hFFF,   "R12 reload reset", int'(v), 4095);
        rd(3'd3, v); check(v == 16'hFFF,   "R12 window reset", int'(v), 4095);
        rd(3'd4, v); check(v == 16'd0,     "R12 status reset", int'(v), 0);
        rd(3'd0, v); check(v == 16'd0,     "R12 key reads zero", int'(v), 0);
        check(wdg_reset_req == 1'b0, "R12 req low", int'(wdg_reset_req), 0);

        // R3 locked write ignored; relock by other key
        wr(3'd2, 16'd7);
        rd(3'd2, v); check(v == 16'hFFF, "R3 locked reload write", int'(v), 4095);
        wr(3'd0, 16'h5555);
        wr(3'd0, 16'hAAAA);
        wr(3'd1, 16'd3);
        rd(3'd1, v); check(v == 16'd0, "R3 relocked div write", int'(v), 0);
        wr(3'd0, 16'h5555);
        wr(3'd1, 16'd3);
        rd(3'd1, v); check(v == 16'd3, "R3 unlocked div write", int'(v), 3);

        // R7 busy bit and write-while-busy
        rd(3'd4, v); check(v == 16'd1, "R7 div busy set", int'(v), 1);
        wr(3'd1, 16'd5);
        wait_idle("R7 busy clears");
        rd(3'd1, v); check(v == 16'd3, "R7 write while busy ignored", int'(v), 3);
        wr(3'd3, 16'd100);
        rd(3'd4, v); check(v == 16'd4, "R7 window busy bit2", int'(v), 4);
        wait_idle("R7 window busy clears");

        // R4 not running: refresh ignored, start cannot be undone
        do_reset(1'b0);
        wr(3'd0, 16'h5555);
        wr(3'd2, 16'd2);
        wait_idle("R7");
        wr(3'd0, 16'hAAAA);
        slow_until_req(300, n);
        check(!wdg_reset_req, "R4 stopped no request", int'(wdg_reset_req), 0);
        wr(3'd0, 16'h1234);
        wr(3'd0, 16'hCCCC);
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'h5555);
        slow_until_req(300, n);
        check(!wdg_reset_req, "R4 start from 0xFFF", int'(wdg_reset_req), 0);
        wr(3'd0, 16'hAAAA);
        slow_until_req(40, n);
        check(wdg_reset_req && n >= 9 && n <= 15, "R4 cannot stop, R2 refresh", n, 12);

        // R1 R9 R2 divider sweep
        for (int code = 0; code < 8; code++) begin
            for (int k = 0; k < 2; k++) begin
                int rel;
                rel = (k == 0) ? 2 : 7;
                d = (code >= 6) ? 256 : (4 << code);
                arm(code, rel);
                wr(3'd0, 16'hAAAA);
                lo = rel * d + 1;
                hi = rel * d + 7;
                slow_until_req(hi + 20, n);
                check(wdg_reset_req && n >= lo && n <= hi, "R9 R1 expiry time", n, rel * d + 4);
            end
        end

        // R5 hardware start
        do_reset(1'b1);
        slow_until_req(17000, n);
        check(wdg_reset_req && n >= 16379 && n <= 16384, "R5 strap start", n, 16381);
        hw_enable = 1'b0;

        // R10 early refresh
        arm(0, 40);
        wr(3'd0, 16'hAAAA);
        wr(3'd0, 16'h5555);
        wr(3'd3, 16'd10);
        wait_idle("R7");
        wr(3'd0, 16'hAAAA);
        slow_until_req(20, n);
        check(wdg_reset_req && n <= 8, "R10 early refresh", n, 4);

        // R10 legal refresh inside window
        arm(0, 40);
        wr(3'd0, 16'hAAAA);
        wr(3'd0, 16'h5555);
        wr(3'd3, 16'd10);
        repeat (140) @(negedge slow_clk);
        check(!wdg_reset_req, "R10 no early fault", int'(wdg_reset_req), 0);
        wr(3'd0, 16'hAAAA);
        slow_until_req(200, n);
        check(wdg_reset_req && n >= 161 && n <= 167, "R10 R2 refresh in window", n, 164);

        // R6 window write reloads, same value
        arm(0, 30);
        wr(3'd0, 16'hAAAA);
        repeat (100) @(negedge slow_clk);
        wr(3'd0, 16'h5555);
        wr(3'd3, 16'hFFF);
        slow_until_req(200, n);
        check(wdg_reset_req && n >= 121 && n <= 127, "R6 window write reload", n, 124);

        // R8 freeze, R11 sticky
        arm(0, 20);
        wr(3'd0, 16'hAAAA);
        dbg_halt = 1'b1;
        slow_until_req(300, n);
        check(!wdg_reset_req, "R8 frozen no request", int'(wdg_reset_req), 0);
        dbg_halt = 1'b0;
        slow_until_req(200, n);
        check(wdg_reset_req && n >= 70 && n <= 90, "R8 resume after halt", n, 83);
        repeat (50) @(negedge slow_clk);
        check(wdg_reset_req, "R11 request sticky", int'(wdg_reset_req), 1);
        do_reset(1'b0);
        check(!wdg_reset_req, "R11 cleared by slow reset", int'(wdg_reset_req), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule